// File: doc/BRIEF.md
# Add-Only EPROM Memory Command Engine

This block is the memory-function controller of a single-wire one-time-programmable memory slave, seen from the byte level. A bit-level front end hands it each received byte with a strobe, asks it for the next byte to transmit, signals a bus reset, and strobes when a programming pulse is present on the line. Inside sit a 128-byte data array of four 32-byte pages, an 8-byte status array, a one-byte scratchpad and a CRC-8 accumulator.

Five commands are served: a plain memory read with one CRC at the end of memory, a memory read with a CRC after every page, a status read, a memory write and a status write. Each command byte is followed by a low and then a high address byte. Writes take the form of a loop: the master sends a data byte, reads back a CRC, applies a programming pulse, then reads back the stored byte. The block then moves to the next address and the loop can run again. Programming can only clear bits. Pages can be locked through the status array.

Top module: `addonly_eprom_engine`

## Requirements
- R1: After `rst`, `tx_byte` reads FFh, the block waits for a command byte, every data cell holds FFh, status bytes 0 to 6 hold FFh and status byte 7 holds 00h.
- R2: Command codes are F0h (read memory), C3h (read with page CRC), AAh (read status), 0Fh (write memory) and 55h (write status). For a read, the first transmitted byte is the CRC-8 (polynomial x^8+x^5+x^4+1, LSB first, seed 0) over the command, the low address byte and the high address byte, as received.
- R3: For a write, the first CRC covers the command, both address bytes and the data byte. The address bytes are taken with every bit above bit 6 forced to 0, and that same forced address selects the cell.
- R4: A programming pulse leaves the selected cell holding the bitwise AND of its old value and the scratchpad. No bit ever goes from 0 back to 1.
- R5: A programming pulse changes storage only when it arrives after the write CRC has been sent. In every other state it is ignored.
- R6: After a pulse, the next transmitted byte is the stored cell value. Reading that byte advances the address (data wraps within 7 bits, status within 3 bits) and seeds the CRC with the new low address byte. The next CRC covers that seed followed by the new data byte.
- R7: If bit p (p = 0 to 3) of status byte 0 is 0, page p (addresses 32p to 32p+31) is never altered, but it still reads normally.
- R8: Status byte 7 always reads 00h, and writes to it have no effect.
- R9: Read memory streams bytes from the start address up to address 7Fh. It then sends one CRC, seeded with 0, over all data bytes sent, and FFh after that.
- R10: Read with page CRC sends a CRC after the last byte of each page. The first CRC covers the start address to the page end. Each later page's CRC restarts from 0. After the last page's CRC, every byte is FFh.
- R11: Read status streams from the start index to byte 7, then sends a CRC over those bytes, then FFh.
- R12: `bus_reset` aborts any command at once. The block returns to waiting for a command, `tx_byte` reads FFh, and no CRC is sent for a read cut short.
- R13: An unknown command byte leaves `tx_byte` at FFh and ignores every later byte until a bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores the erased array |
| bus_reset | input | 1 | Bus reset seen on the line; aborts the current command |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a byte written by the master |
| rx_byte | input | 8 | Byte received from the master |
| tx_req | input | 1 | One-cycle strobe: the master has consumed `tx_byte` through eight read slots |
| vpp_pulse | input | 1 | One-cycle strobe: a programming pulse was applied |
| tx_byte | output | 8 | Byte the block answers with on the next eight read slots |

## Verification
The assertions assume that every strobe lasts one cycle and that no two of `rx_valid`, `tx_req` and `vpp_pulse` fall in the same cycle. They also assume that `rst` is held for at least two cycles, so the add-only check never sees the reset refill as a 0-to-1 change. The bench drives each strobe for exactly one cycle from separate tasks, with at least one idle cycle between strobes, and holds reset for several cycles. It also keeps every address inside its field, except in the one test that deliberately sends a write address above 7Fh.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam logic [7:0] CMD_RD_MEM  = 8'hF0;
    localparam logic [7:0] CMD_RD_PAGE = 8'hC3;
    localparam logic [7:0] CMD_RD_STAT = 8'hAA;
    localparam logic [7:0] CMD_WR_MEM  = 8'h0F;
    localparam logic [7:0] CMD_WR_STAT = 8'h55;

    // x^8+x^5+x^4+1 taken LSB first
    localparam logic [7:0] CRC_POLY_LSBF = 8'h8C;

    typedef enum logic [3:0] {
        ST_CMD, ST_ADL, ST_ADH, ST_HCRC, ST_RDATA, ST_RCRC,
        ST_WDATA, ST_WCRC, ST_WPROG, ST_WVERIFY, ST_DONE
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_RDMEM, OP_RDPAGE, OP_RDSTAT, OP_WRMEM, OP_WRSTAT
    } eng_op_e;

    typedef enum logic [2:0] {
        CRC_HOLD, CRC_CLEAR, CRC_LOAD, CRC_SHIFT, CRC_START
    } crc_op_e;

    typedef struct packed {
        crc_op_e    op;
        logic [7:0] din;
    } crc_ctl_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] c;
        c = acc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY_LSBF;
            else               c = c >> 1;
        end
        return c;
    endfunction

    function automatic eng_op_e decode_cmd(input logic [7:0] b);
        case (b)
            CMD_RD_MEM:  return OP_RDMEM;
            CMD_RD_PAGE: return OP_RDPAGE;
            CMD_RD_STAT: return OP_RDSTAT;
            CMD_WR_MEM:  return OP_WRMEM;
            CMD_WR_STAT: return OP_WRSTAT;
            default:     return OP_NONE;
        endcase
    endfunction

    function automatic logic op_is_write(input eng_op_e op);
        return (op == OP_WRMEM) || (op == OP_WRSTAT);
    endfunction

    function automatic logic op_is_status(input eng_op_e op);
        return (op == OP_RDSTAT) || (op == OP_WRSTAT);
    endfunction

endpackage

// File: rtl/eprom_crc8.sv
module eprom_crc8
    import eprom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  crc_ctl_t   ctl,
    output logic [7:0] crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= 8'h00;
        end else begin
            case (ctl.op)
                CRC_CLEAR: crc <= 8'h00;
                CRC_LOAD:  crc <= ctl.din;
                CRC_SHIFT: crc <= crc8_step(crc, ctl.din);
                CRC_START: crc <= crc8_step(8'h00, ctl.din);
                default:   crc <= crc;
            endcase
        end
    end

endmodule

// File: rtl/eprom_store.sv
module eprom_store
    import eprom_pkg::*;
#(
    parameter  int NPAGE  = 4,
    parameter  int PBYTES = 32,
    parameter  int NSTAT  = 8,
    localparam int MBYTES = NPAGE * PBYTES,
    localparam int MAW    = $clog2(MBYTES),
    localparam int SAW    = $clog2(NSTAT),
    localparam int PAW    = $clog2(PBYTES)
)(
    input  logic           clk,
    input  logic           rst,
    input  logic [MAW-1:0] addr,
    input  logic           mem_we,
    input  logic           stat_we,
    input  logic [7:0]     wdata,
    output logic [7:0]     mem_rd,
    output logic [7:0]     stat_rd
);

    logic [7:0]       mem_q  [MBYTES];
    logic [7:0]       stat_q [NSTAT];
    logic [NPAGE-1:0] wp_n;
    logic [SAW-1:0]   sidx;
    logic [MAW-PAW-1:0] page;

    assign sidx = addr[SAW-1:0];
    assign page = addr[MAW-1:PAW];
    assign wp_n = stat_q[0][NPAGE-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MBYTES; i++) mem_q[i] <= 8'hFF;
            for (int i = 0; i < NSTAT; i++)  stat_q[i] <= (i == NSTAT-1) ? 8'h00 : 8'hFF;
        end else begin
            if (mem_we && wp_n[page])
                mem_q[addr] <= mem_q[addr] & wdata;
            if (stat_we && (sidx != SAW'(NSTAT-1)))
                stat_q[sidx] <= stat_q[sidx] & wdata;
        end
    end

    assign mem_rd  = mem_q[addr];
    assign stat_rd = stat_q[sidx];

    for (genvar i = 0; i < MBYTES; i++) begin : g_cell_chk
        AST_ADD_ONLY: assert property (@(posedge clk) disable iff (rst)
            (mem_q[i] & ~$past(mem_q[i])) == 8'h00);                               // R4
        AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
            !$stable(mem_q[i]) |-> ($past(mem_we) && $past(addr) == MAW'(i)));     // R5
        AST_PAGE_LOCKED: assert property (@(posedge clk) disable iff (rst)
            (mem_we && addr == MAW'(i) && !wp_n[i / PBYTES]) |=> $stable(mem_q[i])); // R7
    end

    for (genvar s = 0; s < NSTAT; s++) begin : g_stat_chk
        AST_STAT_ADD_ONLY: assert property (@(posedge clk) disable iff (rst)
            (stat_q[s] & ~$past(stat_q[s])) == 8'h00);                             // R4
    end

    AST_FACTORY_BYTE: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> stat_q[NSTAT-1] == 8'h00);                                      // R8

endmodule

// File: rtl/eprom_cmd_fsm.sv
module eprom_cmd_fsm
    import eprom_pkg::*;
#(
    parameter  int NPAGE  = 4,
    parameter  int PBYTES = 32,
    parameter  int NSTAT  = 8,
    localparam int MBYTES = NPAGE * PBYTES,
    localparam int MAW    = $clog2(MBYTES),
    localparam int SAW    = $clog2(NSTAT),
    localparam int PAW    = $clog2(PBYTES),
    localparam logic [7:0] AMASK = 8'((1 << MAW) - 1)
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_reset,
    input  logic           rx_valid,
    input  logic [7:0]     rx_byte,
    input  logic           tx_req,
    input  logic           vpp_pulse,
    input  logic [7:0]     mem_rd,
    input  logic [7:0]     stat_rd,
    input  logic [7:0]     crc_in,
    output crc_ctl_t       crc_ctl,
    output logic [MAW-1:0] addr,
    output logic           mem_we,
    output logic           stat_we,
    output logic [7:0]     wdata,
    output logic [7:0]     tx_byte
);

    eng_state_e     state_q, state_d;
    eng_op_e        op_q, op_d;
    logic [MAW-1:0] addr_q, addr_d, addr_inc;
    logic [7:0]     scr_q, scr_d;
    logic           is_stat, is_wr, field_end, page_end;

    assign is_stat = op_is_status(op_q);
    assign is_wr   = op_is_write(op_q);

    always_comb begin
        if (is_stat) begin
            addr_inc  = MAW'(addr_q[SAW-1:0] + 1'b1);
            field_end = &addr_q[SAW-1:0];
        end else begin
            addr_inc  = addr_q + 1'b1;
            field_end = &addr_q;
        end
        page_end = &addr_q[PAW-1:0];
    end

    always_comb begin
        case (state_q)
            ST_HCRC, ST_RCRC, ST_WCRC: tx_byte = crc_in;
            ST_RDATA, ST_WVERIFY:      tx_byte = is_stat ? stat_rd : mem_rd;
            default:                   tx_byte = 8'hFF;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        op_d        = op_q;
        addr_d      = addr_q;
        scr_d       = scr_q;
        crc_ctl.op  = CRC_HOLD;
        crc_ctl.din = 8'h00;
        mem_we      = 1'b0;
        stat_we     = 1'b0;
        if (bus_reset) begin
            state_d    = ST_CMD;
            op_d       = OP_NONE;
            crc_ctl.op = CRC_CLEAR;
        end else begin
            case (state_q)
                ST_CMD: if (rx_valid) begin
                    op_d = decode_cmd(rx_byte);
                    if (decode_cmd(rx_byte) == OP_NONE) begin
                        state_d = ST_DONE;
                    end else begin
                        crc_ctl.op  = CRC_START;
                        crc_ctl.din = rx_byte;
                        state_d     = ST_ADL;
                    end
                end
                ST_ADL: if (rx_valid) begin
                    crc_ctl.op  = CRC_SHIFT;
                    crc_ctl.din = is_wr ? (rx_byte & AMASK) : rx_byte;
                    addr_d      = is_stat ? MAW'(rx_byte[SAW-1:0]) : rx_byte[MAW-1:0];
                    state_d     = ST_ADH;
                end
                ST_ADH: if (rx_valid) begin
                    crc_ctl.op  = CRC_SHIFT;
                    crc_ctl.din = is_wr ? 8'h00 : rx_byte;
                    state_d     = is_wr ? ST_WDATA : ST_HCRC;
                end
                ST_HCRC: if (tx_req) begin
                    crc_ctl.op = CRC_CLEAR;
                    state_d    = ST_RDATA;
                end
                ST_RDATA: if (tx_req) begin
                    crc_ctl.op  = CRC_SHIFT;
                    crc_ctl.din = tx_byte;
                    if (field_end || (op_q == OP_RDPAGE && page_end)) state_d = ST_RCRC;
                    else                                              addr_d  = addr_inc;
                end
                ST_RCRC: if (tx_req) begin
                    if (op_q == OP_RDPAGE && !field_end) begin
                        addr_d     = addr_inc;
                        crc_ctl.op = CRC_CLEAR;
                        state_d    = ST_RDATA;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
                ST_WDATA: if (rx_valid) begin
                    scr_d       = rx_byte;
                    crc_ctl.op  = CRC_SHIFT;
                    crc_ctl.din = rx_byte;
                    state_d     = ST_WCRC;
                end
                ST_WCRC: if (tx_req) state_d = ST_WPROG;
                ST_WPROG: if (vpp_pulse) begin
                    mem_we  = (op_q == OP_WRMEM);
                    stat_we = (op_q == OP_WRSTAT);
                    state_d = ST_WVERIFY;
                end
                ST_WVERIFY: if (tx_req) begin
                    addr_d      = addr_inc;
                    crc_ctl.op  = CRC_LOAD;
                    crc_ctl.din = 8'(addr_inc);
                    state_d     = ST_WDATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CMD;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            scr_q   <= 8'hFF;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            scr_q   <= scr_d;
        end
    end

    assign addr  = addr_q;
    assign wdata = scr_q;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (state_q == ST_CMD && tx_byte == 8'hFF));                     // R12
    AST_DATA_CRC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HCRC && tx_req && !bus_reset) |=> crc_in == 8'h00);          // R9
    AST_PAGE_CRC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RCRC && tx_req && !bus_reset && op_q == OP_RDPAGE && !field_end)
        |=> (crc_in == 8'h00 && state_q == ST_RDATA));                              // R10
    AST_SEED_NEW_ADDR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WVERIFY && tx_req && !bus_reset) |=> crc_in == 8'(addr_q));  // R6
    AST_VERIFY_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WVERIFY && tx_req && !bus_reset && op_q == OP_WRMEM)
        |=> addr_q == MAW'($past(addr_q) + 1'b1));                                  // R6
    AST_UNKNOWN_STUCK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !bus_reset) |=> (state_q == ST_DONE && !mem_we && !stat_we)); // R13

endmodule

// File: rtl/addonly_eprom_engine.sv
module addonly_eprom_engine
    import eprom_pkg::*;
#(
    parameter  int NPAGE  = 4,
    parameter  int PBYTES = 32,
    parameter  int NSTAT  = 8,
    localparam int MAW    = $clog2(NPAGE * PBYTES)
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       vpp_pulse,
    output logic [7:0] tx_byte
);

    crc_ctl_t       crc_ctl;
    logic [7:0]     crc;
    logic [MAW-1:0] addr;
    logic           mem_we, stat_we;
    logic [7:0]     wdata, mem_rd, stat_rd;

    eprom_cmd_fsm #(.NPAGE(NPAGE), .PBYTES(PBYTES), .NSTAT(NSTAT)) u_fsm (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req), .vpp_pulse(vpp_pulse),
        .mem_rd(mem_rd), .stat_rd(stat_rd), .crc_in(crc), .crc_ctl(crc_ctl),
        .addr(addr), .mem_we(mem_we), .stat_we(stat_we), .wdata(wdata), .tx_byte(tx_byte)
    );

    eprom_store #(.NPAGE(NPAGE), .PBYTES(PBYTES), .NSTAT(NSTAT)) u_store (
        .clk(clk), .rst(rst), .addr(addr), .mem_we(mem_we), .stat_we(stat_we),
        .wdata(wdata), .mem_rd(mem_rd), .stat_rd(stat_rd)
    );

    eprom_crc8 u_crc (
        .clk(clk), .rst(rst), .ctl(crc_ctl), .crc(crc)
    );

endmodule

// File: tb/addonly_eprom_engine_test.sv
module addonly_eprom_engine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       vpp_pulse = 1'b0;
    logic [7:0] tx_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] m_mem  [128];
    logic [7:0] m_stat [8];

    addonly_eprom_engine uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .vpp_pulse(vpp_pulse), .tx_byte(tx_byte)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
        end
    end

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] v);
        @(negedge clk); v = tx_byte; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic pulse_vpp();
        @(negedge clk); vpp_pulse = 1'b1;
        @(negedge clk); vpp_pulse = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic model_prog(input bit st, input int a, input logic [7:0] d);
        if (st) begin
            if (a != 7) m_stat[a] = m_stat[a] & d;
        end else if (m_stat[0][a / 32]) begin
            m_mem[a] = m_mem[a] & d;
        end
    endtask

    task automatic wr_seq(input bit st, input logic [7:0] al, input logic [7:0] ah,
                          input int n, input logic [7:0] seed, input string vreq);
        logic [7:0] c, v, d;
        int a;
        a = st ? int'(al[2:0]) : int'(al & 8'h7F);
        c = crc_b(crc_b(crc_b(8'h00, st ? 8'h55 : 8'h0F), al & 8'h7F), 8'h00);
        send(st ? 8'h55 : 8'h0F); send(al); send(ah);
        for (int k = 0; k < n; k++) begin
            d = seed ^ 8'(k * 29);
            send(d);
            if (k == 0) c = crc_b(c, d);
            else        c = crc_b(8'(a), d);
            recv(v);
            chk(v, c, (k == 0) ? "R3" : "R6", "write crc");
            pulse_vpp();
            model_prog(st, a, d);
            recv(v);
            chk(v, st ? m_stat[a] : m_mem[a], vreq, "verify byte");
            a = st ? (a + 1) % 8 : (a + 1) % 128;
        end
        breset();
    endtask

    task automatic rd_seq(input logic [7:0] cmd, input logic [7:0] al, input logic [7:0] ah);
        logic [7:0] c, v, e;
        int a;
        bit st, pg, fend;
        string req;
        st  = (cmd == 8'hAA);
        pg  = (cmd == 8'hC3);
        req = st ? "R11" : (pg ? "R10" : "R9");
        send(cmd); send(al); send(ah);
        recv(v);
        chk(v, crc_b(crc_b(crc_b(8'h00, cmd), al), ah), "R2", "header crc");
        c = 8'h00;
        a = st ? int'(al[2:0]) : int'(al[6:0]);
        while (1) begin
            e = st ? m_stat[a] : m_mem[a];
            recv(v);
            chk(v, e, (st && a == 7) ? "R8" : req, "read data");
            c = crc_b(c, e);
            fend = st ? (a == 7) : (a == 127);
            if (fend || (pg && (a % 32) == 31)) begin
                recv(v);
                chk(v, c, req, "trailing crc");
                c = 8'h00;
                if (fend || !pg) break;
            end
            a++;
        end
        for (int k = 0; k < 2; k++) begin
            recv(v);
            chk(v, 8'hFF, req, "after final crc");
        end
        breset();
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
        for (int i = 0; i < 8; i++)   m_stat[i] = (i == 7) ? 8'h00 : 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_byte, 8'hFF, "R1", "idle tx after reset");

        // R1/R9: erased array, full stream
        rd_seq(8'hF0, 8'h00, 8'h00);
        rd_seq(8'hAA, 8'h00, 8'h00);

        // R3/R6/R4: write run crossing a page boundary
        wr_seq(1'b0, 8'h1E, 8'h00, 4, 8'h3C, "R4");
        // R4: rewrite overlaps, AND result
        wr_seq(1'b0, 8'h1F, 8'h00, 2, 8'hF0, "R4");
        // R3: out-of-range address masked into 0x45
        wr_seq(1'b0, 8'hC5, 8'h12, 2, 8'h81, "R3");
        // sweep one run per page
        for (int p = 0; p < 4; p++) wr_seq(1'b0, 8'(p * 32 + 8), 8'h00, 3, 8'(8'h5A + p), "R4");

        // R5: pulses outside the program window are ignored
        pulse_vpp();
        send(8'h0F); send(8'h50); send(8'h00);
        pulse_vpp();
        send(8'h00);
        pulse_vpp();
        recv(v);
        chk(v, crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h50), 8'h00), 8'h00), "R5", "crc before pulse");
        breset();
        pulse_vpp();
        send(8'hF0); send(8'h50); send(8'h00);
        recv(v);
        recv(v);
        chk(v, 8'hFF, "R5", "cell untouched by stray pulse");
        breset();

        // R7: lock page 1 then try to clear it
        wr_seq(1'b1, 8'h00, 8'h00, 1, 8'hFD, "R7");
        wr_seq(1'b0, 8'h25, 8'h00, 3, 8'h00, "R7");
        wr_seq(1'b0, 8'h28, 8'h00, 1, 8'h00, "R7");
        // R8: factory byte stays zero
        wr_seq(1'b1, 8'h07, 8'h00, 1, 8'h5A, "R8");
        wr_seq(1'b1, 8'h03, 8'h00, 3, 8'h96, "R6");

        // streams with live data
        rd_seq(8'hAA, 8'h00, 8'h00);
        rd_seq(8'hAA, 8'h05, 8'h00);
        rd_seq(8'hF0, 8'h00, 8'h00);
        rd_seq(8'hF0, 8'h7D, 8'h00);
        rd_seq(8'hC3, 8'h1C, 8'h00);
        rd_seq(8'hC3, 8'h00, 8'h00);

        // R12: abort a read part way, no crc, clean restart
        send(8'hF0); send(8'h00); send(8'h00);
        recv(v); recv(v); recv(v);
        breset();
        @(negedge clk);
        chk(tx_byte, 8'hFF, "R12", "tx after abort");
        recv(v);
        chk(v, 8'hFF, "R12", "no crc after abort");
        breset();
        rd_seq(8'hAA, 8'h02, 8'h00);

        // R13: unknown command
        send(8'h99);
        for (int k = 0; k < 3; k++) begin
            recv(v);
            chk(v, 8'hFF, "R13", "unknown command tx");
        end
        send(8'h0F); send(8'h00);
        recv(v);
        chk(v, 8'hFF, "R13", "later bytes ignored");
        breset();
        rd_seq(8'hF0, 8'h60, 8'h00);

        summary();
    end

endmodule